// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Aggregator

This block takes 32 second-level interrupt sources, arranged as four 8-bit banks, and merges them onto 12 first-level interrupt lines and one combined request output. The banks have mixed electrical polarity. Each bank therefore carries a fixed idle pattern, and a source counts as active whenever its synchronised input differs from its idle bit. Sources are not assigned to lines in contiguous runs. A fixed table gives each line one bank and an 8-bit group mask, so some lines collect a single source and others collect a cluster.

Software works through a small byte-wide register port. It can read the normalised activity of each bank and read or write the per-bank source masks and the two line-mask bytes. It can also pick one line and read the lowest pending source behind that line as an encoded number with a valid flag. When the flag is clear, the handler falls back to treating the line itself as the source.

Register map (4-bit address): 0..3 bank activity (read only), 4..7 source masks of banks 0..3, 8 line mask for lines 0..7, 9 line mask for lines 8..11 in bits 3:0, 10 decode line select (bits 3:0), 11 decode result (read only). Unlisted addresses read 0.

Top module: `irq_cascade_top`

## Requirements
- R1: A source n (bank n/8, bit n%8) is active when its synchronised input differs from its bank's idle bit; the idle patterns of banks 0..3 are 0x00, 0xBE, 0xFC, 0xF7, and reading address b (0..3) returns the activity byte of bank b.
- R2: In both source masks (addresses 4..7, bit n%8 of address 4+n/8) and line masks (address 8 for lines 0..7, address 9 bits 3:0 for lines 8..11), a 1 disables and a 0 enables.
- R3: After reset every mask bit is 1, the decode select is 0, all lines and the combined output are 0, and address 9 reads 0x0F.
- R4: A line asserts exactly when one of its grouped sources is active and unmasked and its own line mask bit is 0. The grouping is: sources 0-7 to line 7; 8 to 4; 9-13 to 6; 14 to 8; 15 to 9; 16-17 to 11; 18-21 to 5; 22 to 0; 23 to 1; 24 to 3; 25-26 to 10; 27 to 2. Sources 28-31 drive no line.
- R5: The combined request output is high exactly when at least one line is asserted.
- R6: Reading address 11 returns bit 7 set and bits 4:0 equal to the lowest-numbered active, unmasked source grouped onto the selected line (bank*8 + bit), regardless of that line's own mask.
- R7: When no grouped source of the selected line is active and unmasked, address 11 reads 0x00.
- R8: A write to a mask or select address takes effect at the next clock edge and reads back the written value (line-mask high byte keeps bits 3:0 only).
- R9: A change on a raw input reaches lines and status after exactly two clock edges: after one edge the outputs still show the old value.
- R10: Writes to status and decode addresses change nothing, and a select value of 12 or more makes address 11 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_src | input | 32 | Asynchronous second-level sources, source n at bit n |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| line_irq | output | 12 | First-level interrupt lines |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A wrong mask bit shows at the ports on the next cycle. It lights or hides a line on `line_irq` and `irq_out`, and it changes the mask read-back. A wrong group or idle entry first shows as a line that asserts for a foreign source, or as a status byte that is non-zero with all inputs idle. Either shows up two edges after the input changes. A broken priority encoder shows only on the decode read when two sources of one line are active at once, so the bench sets several sources per line and masks the lowest one away.

// File: rtl/irq_cascade_pkg.sv
// Package: shared constants and fixed tables of the cascaded interrupt block.
// Assumes 8-bit banks; tables cover up to 8 banks and 12 lines.
package irq_cascade_pkg;

    localparam int unsigned ADR_STAT  = 0;   // first bank activity address
    localparam int unsigned ADR_SMASK = 4;   // first source-mask address
    localparam int unsigned ADR_LLO   = 8;   // line mask, lines 0..7
    localparam int unsigned ADR_LHI   = 9;   // line mask, lines 8..11
    localparam int unsigned ADR_SEL   = 10;  // decode line select
    localparam int unsigned ADR_DEC   = 11;  // decode result

    // Bank feeding each first-level line.
    function automatic int line_bank(input int l);
        case (l)
            0, 1, 5, 11: return 2;
            2, 3, 10:    return 3;
            4, 6, 8, 9:  return 1;
            default:     return 0;
        endcase
    endfunction

    // Group mask selecting the bank bits that belong to a line.
    function automatic logic [7:0] line_group(input int l);
        case (l)
            0:       return 8'h40;
            1:       return 8'h80;
            2:       return 8'h08;
            3:       return 8'h01;
            4:       return 8'h01;
            5:       return 8'h3C;
            6:       return 8'h3E;
            7:       return 8'hFF;
            8:       return 8'h40;
            9:       return 8'h80;
            10:      return 8'h06;
            11:      return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    // Input level of each bank when nothing is requesting.
    function automatic logic [7:0] bank_idle(input int b);
        case (b)
            1:       return 8'hBE;
            2:       return 8'hFC;
            3:       return 8'hF7;
            default: return 8'h00;
        endcase
    endfunction

    // Idle levels of all banks concatenated, bank 0 in the low byte.
    function automatic logic [63:0] idle_vec(input int nb);
        logic [63:0] v;
        v = '0;
        for (int b = 0; b < 8; b++) begin
            if (b < nb) v[b*8 +: 8] = bank_idle(b);
        end
        return v;
    endfunction

endpackage

// File: rtl/irq_sync.sv
// Two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; reset loads the idle level.
module irq_sync #(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages; first may go metastable, second is used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/irq_group.sv
// One first-level line: selects its bank, applies group and source masks.
// Assumes LINE indexes the fixed tables of the package.
module irq_group
    import irq_cascade_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int BW    = 8,
    parameter int LINE  = 0
) (
    input  logic [BANKS-1:0][BW-1:0] act,
    input  logic [BANKS-1:0][BW-1:0] smask,
    output logic [BW-1:0]            grp,
    output logic                     pend
);
    localparam int          BK = line_bank(LINE);
    localparam logic [BW-1:0] GM = BW'(line_group(LINE));

    // Active, grouped and unmasked sources of this line.
    always_comb begin
        grp  = act[BK] & GM & ~smask[BK];
        pend = |grp;
    end
endmodule

// File: rtl/irq_pick.sv
// Priority encoder for the selected line: lowest pending bit wins.
// Assumes selects beyond LINES-1 yield no valid result.
module irq_pick
    import irq_cascade_pkg::*;
#(
    parameter int LINES = 12,
    parameter int BW    = 8,
    parameter int IDXW  = 5,
    parameter int SELW  = 4
) (
    input  logic [LINES-1:0][BW-1:0] grp_all,
    input  logic [SELW-1:0]          sel,
    output logic                     valid,
    output logic [IDXW-1:0]          idx
);
    logic [BW-1:0] g;
    int            bk;
    int            bitpos;

    // Pick the selected line's group vector and bank.
    always_comb begin
        g  = '0;
        bk = 0;
        for (int l = 0; l < LINES; l++) begin
            if (sel == SELW'(l)) begin
                g  = grp_all[l];
                bk = line_bank(l);
            end
        end
    end

    // Scan from the top so the lowest set bit is kept last.
    always_comb begin
        bitpos = 0;
        for (int j = BW - 1; j >= 0; j--) begin
            if (g[j]) bitpos = j;
        end
        valid = |g;
        idx   = valid ? IDXW'(bk * BW + bitpos) : '0;
    end
endmodule

// File: rtl/irq_regs.sv
// Register file: source masks, line masks, decode select, read mux.
// Assumes LINES lies between BW+1 and 2*BW; writes are one byte per cycle.
module irq_regs
    import irq_cascade_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int BW    = 8,
    parameter int LINES = 12,
    parameter int AW    = 4,
    parameter int SELW  = 4,
    parameter int IDXW  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            addr,
    input  logic                     wr,
    input  logic [BW-1:0]            wdata,
    input  logic [BANKS-1:0][BW-1:0] status,
    input  logic                     dec_valid,
    input  logic [IDXW-1:0]          dec_idx,
    output logic [BANKS-1:0][BW-1:0] smask,
    output logic [LINES-1:0]         lmask,
    output logic [SELW-1:0]          sel,
    output logic [BW-1:0]            rdata
);
    // Source masks: one byte per bank, reset to all disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smask <= '1;
        end else begin
            for (int b = 0; b < BANKS; b++) begin
                if (wr && addr == AW'(ADR_SMASK + b)) smask[b] <= wdata;
            end
        end
    end

    // Line masks: low byte and partial high byte, reset to all disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lmask <= '1;
        end else if (wr && addr == AW'(ADR_LLO)) begin
            lmask[BW-1:0] <= wdata;
        end else if (wr && addr == AW'(ADR_LHI)) begin
            lmask[LINES-1:BW] <= wdata[LINES-BW-1:0];
        end
    end

    // Decode line select.
    always_ff @(posedge clk) begin
        if (!rst_n)                          sel <= '0;
        else if (wr && addr == AW'(ADR_SEL)) sel <= wdata[SELW-1:0];
    end

    // Read mux over all addresses; unknown addresses read zero.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (addr == AW'(ADR_STAT + b))  rdata = status[b];
            if (addr == AW'(ADR_SMASK + b)) rdata = smask[b];
        end
        if (addr == AW'(ADR_LLO)) rdata = lmask[BW-1:0];
        if (addr == AW'(ADR_LHI)) rdata = BW'(lmask[LINES-1:BW]);
        if (addr == AW'(ADR_SEL)) rdata = BW'(sel);
        if (addr == AW'(ADR_DEC)) rdata = {dec_valid, (BW-1)'(dec_idx)};
    end
endmodule

// File: rtl/irq_cascade_top.sv
// Two-level interrupt aggregator: synchronise, normalise polarity, group
// sources onto first-level lines, mask, and priority-encode one line.
// Assumes the fixed tables in the package match BANKS, BW and LINES.
module irq_cascade_top
    import irq_cascade_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int BW    = 8,
    parameter int LINES = 12,
    parameter int AW    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BANKS*BW-1:0]    raw_src,
    input  logic [AW-1:0]          reg_addr,
    input  logic                   reg_wr,
    input  logic [BW-1:0]          reg_wdata,
    output logic [BW-1:0]          reg_rdata,
    output logic [LINES-1:0]       line_irq,
    output logic                   irq_out
);
    localparam int SRC  = BANKS * BW;
    localparam int IDXW = $clog2(SRC);
    localparam int SELW = $clog2(LINES);
    localparam logic [SRC-1:0] IDLE_VEC = SRC'(idle_vec(BANKS));

    logic [SRC-1:0]            sync_q;
    logic [BANKS-1:0][BW-1:0]  act;
    logic [BANKS-1:0][BW-1:0]  smask_q;
    logic [LINES-1:0]          lmask_q;
    logic [SELW-1:0]           sel_q;
    logic [LINES-1:0][BW-1:0]  grp_all;
    logic [LINES-1:0]          line_pend;
    logic                      dec_valid;
    logic [IDXW-1:0]           dec_idx;

    irq_sync #(.W(SRC), .RST_VAL(IDLE_VEC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_src),
        .q     (sync_q)
    );

    // Polarity normalisation: active means differing from the idle level.
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            act[b] = sync_q[b*BW +: BW] ^ IDLE_VEC[b*BW +: BW];
        end
    end

    generate
        for (genvar l = 0; l < LINES; l++) begin : g_line
            irq_group #(.BANKS(BANKS), .BW(BW), .LINE(l)) u_group (
                .act   (act),
                .smask (smask_q),
                .grp   (grp_all[l]),
                .pend  (line_pend[l])
            );
        end
    endgenerate

    irq_pick #(.LINES(LINES), .BW(BW), .IDXW(IDXW), .SELW(SELW)) u_pick (
        .grp_all (grp_all),
        .sel     (sel_q),
        .valid   (dec_valid),
        .idx     (dec_idx)
    );

    irq_regs #(
        .BANKS(BANKS), .BW(BW), .LINES(LINES),
        .AW(AW), .SELW(SELW), .IDXW(IDXW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .status    (act),
        .dec_valid (dec_valid),
        .dec_idx   (dec_idx),
        .smask     (smask_q),
        .lmask     (lmask_q),
        .sel       (sel_q),
        .rdata     (reg_rdata)
    );

    // First-level gating and combined request.
    always_comb begin
        line_irq = line_pend & ~lmask_q;
        irq_out  = |line_irq;
    end
endmodule

// File: rtl/irq_cascade_chk.sv
// Checker for the aggregator, bound to the top module below.
// Assumes the default address map of the package.
module irq_cascade_chk #(
    parameter int BANKS = 4,
    parameter int BW    = 8,
    parameter int LINES = 12,
    parameter int AW    = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [AW-1:0]            reg_addr,
    input logic                     reg_wr,
    input logic [BW-1:0]            reg_wdata,
    input logic [BW-1:0]            reg_rdata,
    input logic [LINES-1:0]         line_irq,
    input logic                     irq_out,
    input logic [BANKS-1:0][BW-1:0] smask,
    input logic [LINES-1:0]         lmask,
    input logic [LINES-1:0]         line_pend
);
    // R3: coming out of reset every mask bit is set.
    p_reset_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((&smask) && (&lmask)));

    // R8: a bank-0 source-mask write shows on the next cycle.
    p_smask_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(4)) |=> (smask[0] == $past(reg_wdata)));

    // R2: a masked line never asserts.
    p_line_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_irq & lmask) == '0));

    // R4: with every source masked, no line asserts.
    p_lines_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&smask) |-> (line_irq == '0));

    // R5: combined output follows pending, unmasked lines.
    p_irq_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(line_pend & ~lmask)));

    // R6: a valid decode read implies some line has a pending group.
    p_dec_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AW'(11) && reg_rdata[BW-1]) |-> (line_pend != '0));
endmodule

bind irq_cascade_top irq_cascade_chk #(
    .BANKS(BANKS), .BW(BW), .LINES(LINES), .AW(AW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .line_irq  (line_irq),
    .irq_out   (irq_out),
    .smask     (smask_q),
    .lmask     (lmask_q),
    .line_pend (line_pend)
);

// File: tb/irq_cascade_tb.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and
// compares them at the falling edge.
module irq_cascade_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] IDLE = 32'hF7FC_BE00;

    typedef struct {
        logic [3:0]  a;
        logic [7:0]  rd;
        logic [11:0] ln;
        logic        irq;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] raw_src = IDLE;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [11:0] line_irq;
    logic        irq_out;

    item_t       q[$];
    logic        mon_req = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    logic [31:0] act_m = '0;
    logic [31:0] smask_m = '1;
    logic [11:0] lmask_m = '1;
    logic [3:0]  sel_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cascade_top dut_i (
        .clk(clk), .rst_n(rst_n), .raw_src(raw_src),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .line_irq(line_irq), .irq_out(irq_out)
    );

    // Source-to-line map as listed in R4; -1 for unused sources.
    function automatic int src_line(input int s);
        if (s <= 7)  return 7;
        if (s == 8)  return 4;
        if (s <= 13) return 6;
        if (s == 14) return 8;
        if (s == 15) return 9;
        if (s <= 17) return 11;
        if (s <= 21) return 5;
        if (s == 22) return 0;
        if (s == 23) return 1;
        if (s == 24) return 3;
        if (s <= 26) return 10;
        if (s == 27) return 2;
        return -1;
    endfunction

    function automatic logic [11:0] exp_lines();
        logic [11:0] v = '0;
        for (int s = 0; s < 32; s++) begin
            if (src_line(s) >= 0 && act_m[s] && !smask_m[s] && !lmask_m[src_line(s)])
                v[src_line(s)] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [7:0] exp_dec(input int sel);
        for (int s = 0; s < 32; s++) begin
            if (src_line(s) == sel && act_m[s] && !smask_m[s])
                return 8'h80 | 8'(s);
        end
        return 8'h00;
    endfunction

    task automatic chk_full(input logic [3:0] a, input logic [7:0] rd,
                            input logic [11:0] ln, input string tag);
        item_t it;
        @(posedge clk); #1;
        reg_addr = a;
        it.a = a; it.rd = rd; it.ln = ln; it.irq = |ln; it.tag = tag;
        q.push_back(it);
        mon_req = 1'b1;
        @(negedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic chk(input logic [3:0] a, input logic [7:0] rd, input string tag);
        chk_full(a, rd, exp_lines(), tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        if (a >= 4 && a <= 7) smask_m[(a-4)*8 +: 8] = d;
        if (a == 8)  lmask_m[7:0] = d;
        if (a == 9)  lmask_m[11:8] = d[3:0];
        if (a == 10) sel_m = d[3:0];
    endtask

    task automatic set_act(input logic [31:0] v);
        @(posedge clk); #1;
        raw_src = v ^ IDLE;
        act_m = v;
        repeat (2) @(posedge clk);
    endtask

    // Monitor: pop one expected item per request and compare outputs.
    always @(negedge clk) begin
        if (mon_req && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (reg_rdata !== it.rd || line_irq !== it.ln || irq_out !== it.irq) begin
                n_fail++;
                $display("FAIL %s: addr %0d rdata %h exp %h lines %h exp %h irq %b exp %b",
                         it.tag, it.a, reg_rdata, it.rd, line_irq, it.ln, irq_out, it.irq);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R3 reset state
        chk(4'd4, 8'hFF, "R3 source mask reset");
        chk(4'd8, 8'hFF, "R3 line mask lo reset");
        chk(4'd9, 8'h0F, "R3 line mask hi reset");
        chk(4'd10, 8'h00, "R3 select reset");
        // R1 idle pattern reads zero activity
        for (int b = 0; b < 4; b++) chk(4'(b), 8'h00, "R1 idle bank reads zero");
        // R1 activity per bank; R4 all masked keeps lines low
        set_act(32'h0801_2828);
        for (int b = 0; b < 4; b++) chk(4'(b), act_m[b*8 +: 8], "R1 bank activity");
        chk(4'd11, 8'h00, "R4 masked sources give no decode");
        // R8 unmask everything, R4/R5 lines follow the map
        for (int b = 0; b < 4; b++) wr(4'(4 + b), 8'h00);
        wr(4'd8, 8'h00);
        wr(4'd9, 8'h00);
        chk(4'd4, 8'h00, "R8 source mask read-back");
        chk(4'd9, 8'h00, "R8 line mask hi read-back");
        // R6 decode lowest source
        wr(4'd10, 8'd6);
        chk(4'd11, exp_dec(6), "R6 line 6 lowest is 11");
        wr(4'd10, 8'd7);
        chk(4'd11, exp_dec(7), "R6 line 7 lowest is 3");
        wr(4'd10, 8'd11);
        chk(4'd11, exp_dec(11), "R6 line 11 source 16");
        wr(4'd5, 8'h08);
        wr(4'd10, 8'd6);
        chk(4'd11, exp_dec(6), "R6 masked 11 falls to 13");
        // R7 no pending source
        wr(4'd10, 8'd4);
        chk(4'd11, 8'h00, "R7 empty line decodes zero");
        // R10 out-of-range select and ignored writes
        wr(4'd10, 8'd13);
        chk(4'd11, 8'h00, "R10 select above 11");
        wr(4'd0, 8'hFF);
        chk(4'd0, act_m[7:0], "R10 status write ignored");
        wr(4'd11, 8'hFF);
        chk(4'd10, 8'h0D, "R10 decode write ignored");
        // R2 line mask hides line 11
        wr(4'd9, 8'h08);
        chk(4'd9, 8'h08, "R2 line 11 masked");
        wr(4'd8, 8'hFF);
        chk(4'd8, 8'hFF, "R2 low lines masked");
        wr(4'd8, 8'h00);
        wr(4'd9, 8'h00);
        // R4 unused sources 28..31 drive nothing
        set_act(32'hF000_0000);
        chk(4'd3, 8'hF0, "R4 unused sources no line");
        // R9 two-edge input latency
        @(posedge clk); #1;
        raw_src = 32'h0000_0020 ^ IDLE;
        chk_full(4'd0, 8'h00, 12'h000, "R9 one edge keeps old value");
        act_m = 32'h0000_0020;
        chk(4'd0, 8'h20, "R9 second edge shows new value");
        // R5 single source drives the combined output
        chk(4'd11, 8'h00, "R5 combined output single line");
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule